// File: doc/BRIEF.md
# Sliding Window Vector Fetch Sequencer

This block paces the loading of motion vectors into a 3x3 filter window that slides across a motion vector field. A start pulse captures the field size: one count of vectors down a column and one of vectors along a row. The block then visits every window position, row of windows by row of windows. For each position it asks an upstream source for vectors. It passes each accepted vector on to the window storage with its slot coordinates and the ping-pong bank it belongs to. It also marks the end of every loaded column and hands a fully loaded window to the evaluation stage.

The first window of each row needs a full load of nine vectors, and the block flags it with a line-start output. Each later window in the row reuses six vectors and needs only one new column of three. A loaded window waits in the idle bank until the evaluation slot is free. Evaluation takes a fixed number of cycles, and the next window is loaded while the current one is being evaluated. A done pulse follows the end of the last evaluation.

Top module: `wf_fetch_ctrl`

## Requirements
- R1: During and right after synchronous reset, vec_req, line_start, vec_we, col_done, win_ready, eval_busy and frame_done are all low.
- R2: start is acted on only when the block is idle (no window loading, waiting or being evaluated). At that point vec_per_col and vec_per_row are captured. A start pulse at any other time has no effect.
- R3: vec_req is high while a window is loading and the idle bank is free. line_start is high only together with vec_req, and only while the first window of a row is loading.
- R4: A window at the first position of a row takes exactly 9 accepted vectors. Every other window takes exactly 3. vec_req is low in the cycle after the last vector of a window is accepted.
- R5: A vector is accepted on a rising edge where both vec_req and vec_valid are high. vec_valid while vec_req is low has no effect: no vec_we follows and no vector is counted.
- R6: One cycle after an acceptance, vec_we is high. vec_x carries vec_data[15:8] and vec_y carries vec_data[7:0]. wr_row is the vector's index within its window load modulo 3. wr_col is that index divided by 3 for a first-of-row load, and 2 otherwise. wr_bank is 0 for the first window after start and toggles with each window.
- R7: col_done is high for one cycle, one cycle after the 3rd, 6th or 9th vector of a window load is accepted.
- R8: win_ready is high when a loaded window is waiting and evaluation is idle or in its final cycle. eval_busy then stays high for exactly EVAL_CYCLES cycles from the next cycle on, and waiting windows are handed over back to back.
- R9: Loading of the next window, and its vec_req, runs during evaluation of the current window. At most one loaded window waits.
- R10: frame_done is a single-cycle pulse one cycle after the final evaluation cycle of the last window. If either captured dimension is below 3, frame_done pulses in the cycle after start and vec_req never rises.
- R11: A frame evaluates exactly (vec_per_row-2)*(vec_per_col-2) windows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a frame (honoured only when idle) |
| vec_per_col | input | DIM_W | Vectors down one column of the field |
| vec_per_row | input | DIM_W | Vectors along one row of the field |
| vec_valid | input | 1 | Upstream vector present on vec_data |
| vec_data | input | 16 | Vector, x in [15:8], y in [7:0] |
| vec_req | output | 1 | Request vectors for the loading window |
| line_start | output | 1 | Loading window is first in its row |
| vec_we | output | 1 | Write strobe toward window storage |
| vec_x | output | 8 | x component of the written vector |
| vec_y | output | 8 | y component of the written vector |
| wr_row | output | 2 | Row slot of the written vector |
| wr_col | output | 2 | Column slot of the written vector |
| wr_bank | output | 1 | Ping-pong bank of the written vector |
| col_done | output | 1 | A column of the loading window is complete |
| win_ready | output | 1 | A loaded window is handed to evaluation |
| eval_busy | output | 1 | Evaluation of a window in progress |
| frame_done | output | 1 | Last window of the frame evaluated |

## Verification
vec_req, line_start and win_ready follow the state left by the previous edge, so they are due in the same cycle in which that state is reached. vec_we with its data and slot fields, col_done, eval_busy and frame_done are registered and are due one cycle after the edge that causes them. The bench keeps its own cycle model of the load counts, the bank and the evaluation timer. It advances that model on the rising edge and compares every output at the following falling edge, so each result is sampled in the cycle it is due. It also checks window totals and done pulses per frame for continuous, alternating and irregular vec_valid patterns, a start during a busy frame, and a field too small to hold a window.

// File: rtl/wf_pkg.sv
package wf_pkg;
    localparam int WIN      = 3;
    localparam int WIN_AREA = WIN * WIN;
    localparam int IDX_W    = $clog2(WIN_AREA);
    localparam int POS_W    = $clog2(WIN);
    localparam int HALF_W   = 8;
    localparam int VEC_W    = 2 * HALF_W;

    typedef logic [IDX_W-1:0] idx_t;
    typedef logic [POS_W-1:0] pos_t;

    typedef struct packed {
        logic [HALF_W-1:0] x;
        logic [HALF_W-1:0] y;
    } mv_t;

    // index of the final vector of a window load
    function automatic idx_t last_idx(input logic first);
        return first ? idx_t'(WIN_AREA - 1) : idx_t'(WIN - 1);
    endfunction

    function automatic pos_t row_of(input idx_t i);
        return pos_t'(i % idx_t'(WIN));
    endfunction

    function automatic pos_t col_of(input idx_t i, input logic first);
        return first ? pos_t'(i / idx_t'(WIN)) : pos_t'(WIN - 1);
    endfunction
endpackage

// File: rtl/wf_fetch_seq.sv
module wf_fetch_seq
    import wf_pkg::*;
#(
    parameter int DIM_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  logic [DIM_W-1:0] n_col_vecs,
    input  logic [DIM_W-1:0] n_row_vecs,
    input  logic             slot_full,
    input  logic             vec_valid,
    output logic             active,
    output logic             req,
    output logic             line_start,
    output logic             acc,
    output logic             load_done,
    output logic             first,
    output logic             bank,
    output idx_t             lc,
    output logic             go_bad
);
    localparam logic [DIM_W-1:0] EDGE_LOSS = DIM_W'(WIN - 1);
    localparam logic [DIM_W-1:0] MIN_DIM   = DIM_W'(WIN);

    logic [DIM_W-1:0] win_cols, win_rows, fc, fr;
    logic             dims_ok;

    assign dims_ok    = (n_col_vecs >= MIN_DIM) && (n_row_vecs >= MIN_DIM);
    assign go_bad     = go && !dims_ok;
    assign first      = (fc == '0);
    assign req        = active && !slot_full;
    assign line_start = req && first;
    assign acc        = req && vec_valid;
    assign load_done  = acc && (lc == last_idx(first));

    always_ff @(posedge clk) begin
        if (rst) begin
            active   <= 1'b0;
            win_cols <= '0;
            win_rows <= '0;
            fc       <= '0;
            fr       <= '0;
            lc       <= '0;
            bank     <= 1'b0;
        end else if (go) begin
            win_cols <= n_row_vecs - EDGE_LOSS;
            win_rows <= n_col_vecs - EDGE_LOSS;
            active   <= dims_ok;
            fc       <= '0;
            fr       <= '0;
            lc       <= '0;
            bank     <= 1'b0;
        end else if (acc) begin
            if (load_done) begin
                lc   <= '0;
                bank <= ~bank;
                if (fc == win_cols - 1'b1) begin
                    fc <= '0;
                    if (fr == win_rows - 1'b1) active <= 1'b0;
                    else fr <= fr + 1'b1;
                end else begin
                    fc <= fc + 1'b1;
                end
            end else begin
                lc <= lc + 1'b1;
            end
        end
    end

    p_load_index_bound_r4: assert property (@(posedge clk) disable iff (rst)
        active |-> (lc <= last_idx(first)));
    p_req_drops_after_load_r4: assert property (@(posedge clk) disable iff (rst)
        load_done |=> !req);
endmodule

// File: rtl/wf_vec_route.sv
module wf_vec_route
    import wf_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             acc,
    input  logic [VEC_W-1:0] vec_data,
    input  idx_t             lc,
    input  logic             first,
    input  logic             bank,
    output logic             vec_we,
    output logic [HALF_W-1:0] vec_x,
    output logic [HALF_W-1:0] vec_y,
    output pos_t             wr_row,
    output pos_t             wr_col,
    output logic             wr_bank,
    output logic             col_done
);
    mv_t mv;
    assign mv = mv_t'(vec_data);

    always_ff @(posedge clk) begin
        if (rst) begin
            vec_we   <= 1'b0;
            col_done <= 1'b0;
            vec_x    <= '0;
            vec_y    <= '0;
            wr_row   <= '0;
            wr_col   <= '0;
            wr_bank  <= 1'b0;
        end else begin
            vec_we   <= acc;
            col_done <= acc && (row_of(lc) == pos_t'(WIN - 1));
            if (acc) begin
                vec_x   <= mv.x;
                vec_y   <= mv.y;
                wr_row  <= row_of(lc);
                wr_col  <= col_of(lc, first);
                wr_bank <= bank;
            end
        end
    end

    p_write_follows_accept_r5: assert property (@(posedge clk) disable iff (rst)
        acc |=> vec_we);
    p_column_end_strobe_r7: assert property (@(posedge clk) disable iff (rst)
        col_done |-> ($past(acc) && vec_we));
endmodule

// File: rtl/wf_eval_slot.sv
module wf_eval_slot #(
    parameter int EVAL_CYCLES = 12
) (
    input  logic clk,
    input  logic rst,
    input  logic load_done,
    input  logic fetch_active,
    input  logic go_bad,
    output logic buf_full,
    output logic eval_busy,
    output logic win_ready,
    output logic done
);
    localparam int CNT_W = (EVAL_CYCLES > 2) ? $clog2(EVAL_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(EVAL_CYCLES - 1);

    logic [CNT_W-1:0] ecnt;
    logic             eval_last;

    assign eval_last = eval_busy && (ecnt == '0);
    assign win_ready = buf_full && (!eval_busy || eval_last);

    always_ff @(posedge clk) begin
        if (rst) begin
            buf_full  <= 1'b0;
            eval_busy <= 1'b0;
            ecnt      <= '0;
            done      <= 1'b0;
        end else begin
            done <= go_bad || (eval_last && !buf_full && !load_done && !fetch_active);
            if (win_ready) begin
                eval_busy <= 1'b1;
                ecnt      <= CNT_TOP;
            end else if (eval_busy) begin
                if (ecnt == '0) eval_busy <= 1'b0;
                else ecnt <= ecnt - 1'b1;
            end
            if (win_ready) buf_full <= 1'b0;
            else if (load_done) buf_full <= 1'b1;
        end
    end

    p_handover_starts_eval_r8: assert property (@(posedge clk) disable iff (rst)
        win_ready |=> (eval_busy && ecnt == CNT_TOP));
    p_done_single_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    p_one_waiting_window_r9: assert property (@(posedge clk) disable iff (rst)
        (buf_full && !win_ready) |=> buf_full);
endmodule

// File: rtl/wf_fetch_ctrl.sv
module wf_fetch_ctrl
    import wf_pkg::*;
#(
    parameter int DIM_W       = 9,
    parameter int EVAL_CYCLES = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [DIM_W-1:0]  vec_per_col,
    input  logic [DIM_W-1:0]  vec_per_row,
    input  logic              vec_valid,
    input  logic [VEC_W-1:0]  vec_data,
    output logic              vec_req,
    output logic              line_start,
    output logic              vec_we,
    output logic [HALF_W-1:0] vec_x,
    output logic [HALF_W-1:0] vec_y,
    output logic [POS_W-1:0]  wr_row,
    output logic [POS_W-1:0]  wr_col,
    output logic              wr_bank,
    output logic              col_done,
    output logic              win_ready,
    output logic              eval_busy,
    output logic              frame_done
);
    logic fetch_active, acc, load_done, first, bank, go_bad, buf_full, go;
    idx_t lc;

    assign go = start && !fetch_active && !buf_full && !eval_busy;

    wf_fetch_seq #(.DIM_W(DIM_W)) u_seq (
        .clk(clk), .rst(rst), .go(go),
        .n_col_vecs(vec_per_col), .n_row_vecs(vec_per_row),
        .slot_full(buf_full), .vec_valid(vec_valid),
        .active(fetch_active), .req(vec_req), .line_start(line_start),
        .acc(acc), .load_done(load_done), .first(first), .bank(bank),
        .lc(lc), .go_bad(go_bad)
    );

    wf_vec_route u_route (
        .clk(clk), .rst(rst), .acc(acc), .vec_data(vec_data),
        .lc(lc), .first(first), .bank(bank),
        .vec_we(vec_we), .vec_x(vec_x), .vec_y(vec_y),
        .wr_row(wr_row), .wr_col(wr_col), .wr_bank(wr_bank),
        .col_done(col_done)
    );

    wf_eval_slot #(.EVAL_CYCLES(EVAL_CYCLES)) u_slot (
        .clk(clk), .rst(rst), .load_done(load_done),
        .fetch_active(fetch_active), .go_bad(go_bad),
        .buf_full(buf_full), .eval_busy(eval_busy),
        .win_ready(win_ready), .done(frame_done)
    );

    p_line_start_in_load_r3: assert property (@(posedge clk) disable iff (rst)
        line_start |-> (vec_req && fetch_active));
    p_busy_start_ignored_r2: assert property (@(posedge clk) disable iff (rst)
        (start && eval_busy && fetch_active) |=> fetch_active);
endmodule

// File: tb/wf_fetch_ctrl_tb_top.sv
module wf_fetch_ctrl_tb_top;
    localparam int EV = 12;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [8:0]  vpc = '0, vpr = '0;
    logic        vvalid = 1'b0;
    logic [15:0] vdata = '0;
    logic        req, lstart, we, wbank, cdone, ready, busy, fdone;
    logic [7:0]  vx, vy;
    logic [1:0]  wrow, wcol;

    always #4 clk = ~clk;

    wf_fetch_ctrl #(.DIM_W(9), .EVAL_CYCLES(EV)) dut_i (
        .clk(clk), .rst(rst), .start(start), .vec_per_col(vpc), .vec_per_row(vpr),
        .vec_valid(vvalid), .vec_data(vdata), .vec_req(req), .line_start(lstart),
        .vec_we(we), .vec_x(vx), .vec_y(vy), .wr_row(wrow), .wr_col(wcol),
        .wr_bank(wbank), .col_done(cdone), .win_ready(ready), .eval_busy(busy),
        .frame_done(fdone)
    );

    int checks = 0, fails = 0, cyc = 0;
    int win_cnt = 0, done_cnt = 0, req_seen = 0;
    bit cmp_en = 1'b0;

    // behavioural reference state
    bit m_active, m_full, m_busy, m_bank;
    int m_ecnt, m_fc, m_fr, m_lc, m_wc, m_wr;
    bit e_we, e_cd, e_done, e_bank;
    int e_x, e_y, e_row, e_col;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", tag, cyc, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog expired: actual=%0d expected<=%0d", cyc, 150000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    always @(posedge clk) begin
        if (rst) begin
            m_active = 0; m_full = 0; m_busy = 0; m_bank = 0;
            m_ecnt = 0; m_fc = 0; m_fr = 0; m_lc = 0; m_wc = 0; m_wr = 0;
            e_we = 0; e_cd = 0; e_done = 0; e_bank = 0;
            e_x = 0; e_y = 0; e_row = 0; e_col = 0;
        end else begin
            bit r, a, fr_ready, ld, idle;
            int need;
            r = m_active && !m_full;
            a = r && vvalid;
            fr_ready = m_full && (!m_busy || m_ecnt == 0);
            need = (m_fc == 0) ? 9 : 3;
            ld = a && (m_lc == need - 1);
            idle = !m_active && !m_full && !m_busy;
            e_we = a;
            e_cd = a && (m_lc % 3 == 2);
            if (a) begin
                e_x = int'(vdata[15:8]); e_y = int'(vdata[7:0]);
                e_row = m_lc % 3;
                e_col = (m_fc == 0) ? m_lc / 3 : 2;
                e_bank = m_bank;
            end
            e_done = (m_busy && m_ecnt == 0 && !m_full && !ld && !m_active) ||
                     (start && idle && (vpc < 3 || vpr < 3));
            if (fr_ready) begin m_busy = 1; m_ecnt = EV - 1; m_full = 0; end
            else if (m_busy) begin
                if (m_ecnt == 0) m_busy = 0; else m_ecnt--;
            end
            if (ld) m_full = 1;
            if (a) begin
                if (ld) begin
                    m_lc = 0; m_bank = !m_bank;
                    if (m_fc == m_wc - 1) begin
                        m_fc = 0;
                        if (m_fr == m_wr - 1) m_active = 0; else m_fr++;
                    end else m_fc++;
                end else m_lc++;
            end
            if (start && idle) begin
                m_wc = int'(vpr) - 2; m_wr = int'(vpc) - 2;
                m_active = (vpc >= 3 && vpr >= 3);
                m_fc = 0; m_fr = 0; m_lc = 0; m_bank = 0;
            end
        end
    end

    always @(negedge clk) begin
        if (cmp_en && !rst) begin
            bit xr, xl, xd;
            xr = m_active && !m_full;
            xl = xr && (m_fc == 0);
            xd = m_full && (!m_busy || m_ecnt == 0);
            chk(req == xr, "R3 vec_req", req, xr);
            chk(lstart == xl, "R3 line_start", lstart, xl);
            chk(we == e_we, "R5 vec_we", we, e_we);
            if (e_we) begin
                chk(vx == e_x[7:0], "R6 vec_x", vx, e_x);
                chk(vy == e_y[7:0], "R6 vec_y", vy, e_y);
                chk(wrow == e_row[1:0], "R6 wr_row", wrow, e_row);
                chk(wcol == e_col[1:0], "R6 wr_col", wcol, e_col);
                chk(wbank == e_bank, "R6 wr_bank", wbank, e_bank);
            end
            chk(cdone == e_cd, "R7 col_done", cdone, e_cd);
            chk(ready == xd, "R8 win_ready", ready, xd);
            chk(busy == m_busy, "R9 eval_busy", busy, m_busy);
            chk(fdone == e_done, "R10 frame_done", fdone, e_done);
            if (ready) win_cnt++;
            if (fdone) done_cnt++;
            if (req) req_seen++;
        end
    end

    logic [15:0] lfsr = 16'hACE1;

    task automatic run_frame(input int c, input int r, input int mode, input bit poke);
        int guard, exp_w;
        win_cnt = 0; done_cnt = 0; req_seen = 0;
        exp_w = (c >= 3 && r >= 3) ? (c - 2) * (r - 2) : 0;
        @(negedge clk);
        vpc = 9'(c); vpr = 9'(r); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        guard = 0;
        while (done_cnt == 0 && guard < 20000) begin
            case (mode)
                0: vvalid = 1'b1;
                1: vvalid = ~vvalid;
                default: begin
                    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                    vvalid = lfsr[0];
                end
            endcase
            vdata = vdata + 16'h3B17;
            if (poke && guard == 25) begin start = 1'b1; vpc = 9'd7; vpr = 9'd9; end
            else start = 1'b0;
            @(negedge clk);
            guard++;
        end
        start = 1'b0;
        vvalid = 1'b1;
        repeat (4) @(negedge clk);
        vvalid = 1'b0;
        chk(win_cnt == exp_w, "R11 windows per frame", win_cnt, exp_w);
        chk(done_cnt == 1, "R10 done pulses", done_cnt, 1);
        if (exp_w == 0) chk(req_seen == 0, "R10 no request on small field", req_seen, 0);
        if (poke) chk(win_cnt == exp_w, "R2 busy start ignored", win_cnt, exp_w);
    endtask

    initial begin
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        cmp_en = 1'b1;
        // R1: reset state at the ports
        chk({req, lstart, we, cdone, ready, busy, fdone} == 7'b0, "R1 reset outputs",
            int'({req, lstart, we, cdone, ready, busy, fdone}), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(req == 1'b0, "R2 no activity before start", req, 0);
        run_frame(4, 5, 0, 1'b1);   // R4 R9: continuous input, busy start
        run_frame(3, 3, 1, 1'b0);   // single window, alternating valid (R5)
        run_frame(2, 6, 0, 1'b0);   // R10 field too small
        run_frame(5, 4, 2, 1'b0);   // irregular valid
        run_frame(6, 7, 0, 1'b0);   // R8 back-to-back handover
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule